// File: doc/BRIEF.md
# Partitioned 8x16 Rounding Multiplier

This unit multiplies signed 16-bit lanes of a 64-bit operand word by 8-bit factors taken from a second 64-bit word. It produces either four rounded 16-bit lane results or two full 32-bit products. A 3-bit mode code selects one of seven ways of pairing multiplicands with factors. Each product is formed at 32 bits. When the low product byte is above 0x7F, 0x100 is added before the result field is taken. Lane 0 is the least significant 16 bits of each word.

A request is a single cycle with `in_valid` high. The result is registered and appears one clock later, with `out_valid` high for that one cycle. A two-state machine tracks the output slot. `ST_IDLE` holds when no request arrives, and `ST_OUT` is entered on any cycle with `in_valid`. There are two transitions: `GO_OUT` (in_valid high) and `GO_IDLE` (in_valid low). Both can be taken from either state. The result register keeps its value until the next request.

Top module: `pmul_unit`

## Requirements
- R1: While `rst_n` is low, the next clock shows `out_valid` = 0 and `result` = 0.
- R2: A cycle with `in_valid` high gives `out_valid` high and a new `result` on the next cycle. A cycle with `in_valid` low gives `out_valid` low and an unchanged `result` on the next cycle. Back-to-back requests each produce their own result.
- R3: Mode 0 (per lane): result lane i (bits 16i+15..16i) is the rounded field of signed `opb` lane i times the unsigned `opa` byte i (bits 8i+7..8i), for i = 0..3.
- R4: Rounding: the product p is signed and at least 24 bits wide. If p[7:0] > 0x7F, then p becomes p + 0x100. A 16-bit lane result is bits [23:8] of the adjusted p.
- R5: Mode 1 (upper broadcast): every lane i uses signed `opb` bits 31..16 times the unsigned `opa` byte i.
- R6: Mode 2 (lower broadcast): every lane i uses signed `opb` bits 15..0 times the unsigned `opa` byte i.
- R7: Mode 3 (upper signed byte): lane i uses signed `opb` lane i times the signed byte at `opa` bits 16i+15..16i+8.
- R8: Mode 4 (lower unsigned byte): lane i uses signed `opb` lane i times the unsigned byte at `opa` bits 16i+7..16i.
- R9: Mode 5 (wide, upper byte): for i = 0 and 1, `result` bits 32i+31..32i hold the full rounded 32-bit product of signed `opb` lane i and signed `opa` bits 16i+15..16i+8. Operand lanes 2 and 3 have no effect.
- R10: Mode 6 (wide, lower byte): the same as R9, but the factor is the unsigned `opa` bits 16i+7..16i.
- R11: Mode 7 is reserved and yields `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| mode | input | 3 | Lane-selection variant, codes 0..7 |
| opa | input | 64 | Factor word (bytes) |
| opb | input | 64 | Multiplicand word (signed 16-bit lanes) |
| out_valid | output | 1 | Result valid, one cycle after a request |
| result | output | 64 | Registered lane results |

## Verification
The hardest conditions to reach from the ports are the rounding edge cases. These are a low product byte of exactly 0x80 against 0x7F, and a negative product whose adjustment carries back across zero. Random words almost never land on them. Hand-built vectors force the exact byte values on chosen lanes, and the wide modes get non-zero data in lanes 2 and 3 to show that those lanes are ignored. A pseudo-random sweep over every mode code then checks each result against a lane-by-lane arithmetic model, and a directed test sends requests back to back while changing operands between results.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    typedef enum logic [2:0] {
        MD_PERLANE = 3'd0,
        MD_BC_UP   = 3'd1,
        MD_BC_LO   = 3'd2,
        MD_UPSB    = 3'd3,
        MD_LOUB    = 3'd4,
        MD_DW_UP   = 3'd5,
        MD_DW_LO   = 3'd6,
        MD_RSVD    = 3'd7
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } st_e;

endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
    parameter int MC_W   = 16,
    parameter int FAC_W  = 9,
    parameter int PROD_W = 32,
    parameter int RND_B  = 8
) (
    input  logic signed [MC_W-1:0]   mcand,
    input  logic signed [FAC_W-1:0]  fac,
    output logic        [PROD_W-1:0] rounded
);
    localparam logic [PROD_W-1:0] RND_INC = PROD_W'(1) << RND_B;

    logic signed [PROD_W-1:0] m_ext;
    logic signed [PROD_W-1:0] f_ext;
    logic signed [PROD_W-1:0] prod;

    assign m_ext = PROD_W'(mcand);
    assign f_ext = PROD_W'(fac);
    assign prod  = m_ext * f_ext;

    // half-up on the low byte: its top bit set means the byte exceeds 0x7F
    assign rounded = prod[RND_B-1] ? (prod + RND_INC) : prod;
endmodule

// File: rtl/pmul_factor_sel.sv
module pmul_factor_sel
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int BYTE_W = 8
) (
    input  mode_e                                md,
    input  logic [LANES*LANE_W-1:0]              opa,
    input  logic [LANES*LANE_W-1:0]              opb,
    output logic [LANES-1:0][LANE_W-1:0]         mcand,
    output logic [LANES-1:0][BYTE_W:0]           fac
);
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            unique case (md)
                MD_BC_UP: mcand[i] = opb[LANE_W +: LANE_W];
                MD_BC_LO: mcand[i] = opb[0 +: LANE_W];
                default:  mcand[i] = opb[i*LANE_W +: LANE_W];
            endcase
            unique case (md)
                MD_UPSB, MD_DW_UP:
                    fac[i] = {opa[i*LANE_W + LANE_W - 1],
                              opa[i*LANE_W + BYTE_W +: BYTE_W]};
                MD_LOUB, MD_DW_LO:
                    fac[i] = {1'b0, opa[i*LANE_W +: BYTE_W]};
                default:
                    fac[i] = {1'b0, opa[i*BYTE_W +: BYTE_W]};
            endcase
        end
    end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int BYTE_W = 8,
    parameter int PROD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [2:0]                mode,
    input  logic [LANES*LANE_W-1:0]   opa,
    input  logic [LANES*LANE_W-1:0]   opb,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   result
);
    localparam int WORD_W     = LANES * LANE_W;
    localparam int FAC_W      = BYTE_W + 1;
    localparam int WIDE_LANES = WORD_W / PROD_W;
    localparam int FLD_HI     = LANE_W + BYTE_W - 1;

    mode_e                              md;
    st_e                                state_q, state_d;
    logic [LANES-1:0][LANE_W-1:0]       mcand;
    logic [LANES-1:0][FAC_W-1:0]        fac;
    logic [LANES-1:0][PROD_W-1:0]       rnd;
    logic [WORD_W-1:0]                  result_d, result_q;

    assign md = mode_e'(mode);

    pmul_factor_sel #(
        .LANES (LANES),
        .LANE_W(LANE_W),
        .BYTE_W(BYTE_W)
    ) u_sel (
        .md   (md),
        .opa  (opa),
        .opb  (opb),
        .mcand(mcand),
        .fac  (fac)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmul_lane #(
            .MC_W  (LANE_W),
            .FAC_W (FAC_W),
            .PROD_W(PROD_W),
            .RND_B (BYTE_W)
        ) u_lane (
            .mcand  (mcand[g]),
            .fac    (fac[g]),
            .rounded(rnd[g])
        );
        if (g >= WIDE_LANES) begin : g_narrow_only
            logic unused_edges;
            assign unused_edges = ^{rnd[g][PROD_W-1:FLD_HI+1], rnd[g][BYTE_W-1:0]};
        end
    end

    // result assembly
    always_comb begin
        result_d = '0;
        unique case (md)
            MD_DW_UP, MD_DW_LO: begin
                for (int i = 0; i < WIDE_LANES; i++)
                    result_d[i*PROD_W +: PROD_W] = rnd[i];
            end
            MD_RSVD: result_d = '0;
            default: begin
                for (int i = 0; i < LANES; i++)
                    result_d[i*LANE_W +: LANE_W] = rnd[i][FLD_HI:BYTE_W];
            end
        endcase
    end

    // next state: GO_OUT on a request, GO_IDLE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result_q <= '0;
        else if (in_valid) result_q <= result_d;
    end

    assign out_valid = (state_q == ST_OUT);
    assign result    = result_q;
endmodule

// File: rtl/pmul_unit_chk.sv
module pmul_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  mode,
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic        out_valid,
    input logic [63:0] result
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == 64'd0)); // R1

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd7) |=> result == 64'd0); // R11

    AST_BCAST_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd2 && opa[7:0] == opa[15:8])
        |=> result[15:0] == result[31:16]); // R6

    AST_LOUB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd4 && opa[7:0] == 8'd0)
        |=> result[15:0] == 16'd0); // R8

    AST_WIDE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd6 && !opb[15] && !opb[31])
        |=> (!result[31] && !result[63])); // R10
endmodule

bind pmul_unit pmul_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mode     (mode),
    .opa      (opa),
    .opb      (opb),
    .out_valid(out_valid),
    .result   (result)
);

// File: tb/pmul_unit_tb.sv
`timescale 1ns/1ps
module pmul_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [63:0] opa = 64'd0;
    logic [63:0] opb = 64'd0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pmul_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  md;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] e;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R3 per lane
        '{8'd3,  3'd0, 64'h0000_0000_0403_0201, 64'h0080_FF00_0200_0100, 64'h0002_FFFD_0004_0001},
        // R4 rounding: 0x80 up, 0x7F down, negative carry to zero
        '{8'd4,  3'd0, 64'h0000_0000_0180_0101, 64'hFF00_FFFF_007F_0080, 64'hFFFF_0000_0000_0001},
        // R5 upper broadcast
        '{8'd5,  3'd1, 64'hFFFF_FFFF_0403_0201, 64'h1234_5678_0200_9ABC, 64'h0008_0006_0004_0002},
        // R6 lower broadcast
        '{8'd6,  3'd2, 64'h0000_0000_FF03_0201, 64'h1111_2222_3333_FF00, 64'hFF01_FFFD_FFFE_FFFF},
        // R7 upper signed byte
        '{8'd7,  3'd3, 64'h7F00_8000_FF00_02FF, 64'h0200_0100_0300_0100, 64'h00FE_FF80_FFFD_0002},
        // R8 lower unsigned byte
        '{8'd8,  3'd4, 64'h8001_0080_FF02_12FF, 64'h7FFF_0001_FF00_0100, 64'h0080_0001_FFFE_00FF},
        // R9 wide upper byte, lanes 2/3 filled with junk
        '{8'd9,  3'd5, 64'hDEAD_BEEF_0311_8055, 64'hCAFE_F00D_FFFE_7FFF, 64'h0000_00FA_FFC0_0180},
        // R10 wide lower byte
        '{8'd10, 3'd6, 64'h1234_5678_AB10_CDFF, 64'h9999_8888_0123_8000, 64'h0000_1230_FF80_8000},
        // R11 reserved code
        '{8'd11, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, 64'h0000_0000_0000_0000}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // arithmetic model written from the requirements
    function automatic logic [63:0] model(input logic [2:0] md, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            logic signed [63:0] m, f, p;
            if (md == 3'd1)      m = $signed(b[31:16]);
            else if (md == 3'd2) m = $signed(b[15:0]);
            else                 m = $signed(b[16*i +: 16]);
            if (md == 3'd3 || md == 3'd5)      f = $signed(a[16*i+8 +: 8]);
            else if (md == 3'd4 || md == 3'd6) f = {56'd0, a[16*i +: 8]};
            else                               f = {56'd0, a[8*i +: 8]};
            p = m * f;
            if (p[7:0] > 8'h7F) p = p + 64'sd256;
            if (md <= 3'd4)                      r[16*i +: 16] = p[23:8];
            else if (md != 3'd7 && i < 2)        r[32*i +: 32] = p[31:0];
        end
        return r;
    endfunction

    task automatic issue(input logic [2:0] md, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; mode = md; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf, a, b, held;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 result in reset", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].md, VECS[k].a, VECS[k].b);
            check($sformatf("R%0d vector %0d valid", VECS[k].req, k), {63'd0, out_valid}, 64'd1);
            check($sformatf("R%0d vector %0d", VECS[k].req, k), result, VECS[k].e);
        end

        // R2 hold with operands changing and no request
        held = result;
        @(negedge clk);
        mode = 3'd0; opa = '1; opb = 64'h0100_0100_0100_0100;
        check("R2 out_valid drops", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check("R2 result held", result, held);

        // R2 back-to-back requests
        @(negedge clk);
        in_valid = 1'b1; mode = VECS[0].md; opa = VECS[0].a; opb = VECS[0].b;
        @(negedge clk);
        mode = VECS[2].md; opa = VECS[2].a; opb = VECS[2].b;
        check("R2 back-to-back first", result, VECS[0].e);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 back-to-back second", result, VECS[2].e);
        check("R2 back-to-back valid", {63'd0, out_valid}, 64'd1);

        // R9 wide upper lanes ignored: change lanes 2/3 only
        issue(3'd5, 64'h0000_0000_0311_8055, 64'h0000_0000_FFFE_7FFF);
        check("R9 upper lanes ignored", result, VECS[6].e);

        // sweep every mode code with pseudo-random words (R3..R11)
        lf = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 160; n++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
            a = lf;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
            b = lf;
            issue(3'(n % 8), a, b);
            check($sformatf("R3-R11 sweep mode %0d", n % 8), result, model(3'(n % 8), a, b));
        end

        // R1 reset mid-run clears
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 result after reset", result, 64'd0);
        check("R1 valid after reset", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule